// File: doc/BRIEF.md
# Round-Robin TLB Lock Arbiter

This block arbitrates one hardware lock that serialises translation-table updates among several hardware threads. Each thread raises a one-cycle lock or unlock request. The arbiter keeps a four-valued state for every thread (free, waiting, queued, owner) and one shared held bit. For every accepted request it tells the requesting thread whether its instruction completes, whether the thread must halt, and whether the request was an error.

When the owner releases the lock while other threads wait, the lock is not dropped. It is reserved for the next waiting thread in circular order, starting at the thread after the releaser. That thread moves to the queued state and receives a wake pulse. When it reissues its lock request, it becomes the owner. The halting mechanism of the threads and the translation entries are outside this block.

Requests are taken one per cycle. When several threads request in the same cycle, the lowest thread index wins. Every response is a registered pulse one cycle long.

Top module: `lock_arbiter`

## Requirements
- R1: Reset (synchronous, active high) puts every thread in the free state and clears the held bit. In the first cycle after reset all response outputs and `lock_held` are 0.
- R2: A lock request while the held bit is clear makes the requester owner, sets the held bit and pulses its `complete` bit.
- R3: A lock request while the held bit is set, from a thread that is free or already waiting, pulses its `halt` bit and leaves it waiting. It produces no `complete` and no `err`.
- R4: A lock request from the current owner pulses its `complete`, `halt` and `err` bits together. The thread stays owner, so its next unlock succeeds.
- R5: An unlock while the held bit is clear, or from a thread that is not owner, pulses only that thread's `err` bit. It changes no state and leaves `lock_held` as it was.
- R6: A valid unlock with no waiting thread pulses the releaser's `complete` bit, returns it to free and clears `lock_held`.
- R7: A valid unlock with waiters pulses the releaser's `complete` bit. In the same cycle it pulses `wake` for the first waiting thread in the order releaser+1, releaser+2, … modulo the thread count. That thread becomes queued and `lock_held` stays 1.
- R8: A lock request from a queued thread makes it owner and pulses its `complete` bit.
- R9: Bit i of every request and response vector belongs to thread i. When several threads request in one cycle, only the lowest index is served. The others get no pulse and keep their state.
- R10: A thread that raises lock and unlock together is treated as making a lock request.
- R11: Responses appear in the cycle after the request and last one cycle. Each of `complete`, `halt`, `err` and `wake` has at most one bit set in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_req | input | N_THREADS | Per-thread lock request, bit i from thread i |
| unlock_req | input | N_THREADS | Per-thread unlock request, bit i from thread i |
| complete | output | N_THREADS | Per-thread pulse: the instruction completes |
| halt | output | N_THREADS | Per-thread pulse: the thread must halt |
| wake | output | N_THREADS | Per-thread pulse: the lock has been reserved for this thread |
| err | output | N_THREADS | Per-thread pulse: double lock or invalid unlock |
| lock_held | output | 1 | Shared held bit: the lock is owned or reserved |

## Verification
A handover is the one case where two threads receive pulses in the same cycle: the releaser gets `complete` and the chosen waiter gets `wake`. The bench provokes this with waiters placed both above and below the releaser, so the search is seen both to advance in circular order and to wrap past the highest index. For each handover it checks that exactly the expected two bits are set on two different threads and that `lock_held` never drops. It also raises requests from two threads in the same cycle, and a lock and an unlock from one thread, and judges from the pulses that only the lowest-index request was served.

// File: rtl/lock_arb_pkg.sv
package lock_arb_pkg;

    // Thread index width; supports up to eight threads.
    localparam int TID_W = 3;

    typedef logic [TID_W-1:0] tid_t;

    typedef enum logic [1:0] {
        TS_FREE  = 2'd0,
        TS_WAIT  = 2'd1,
        TS_QUEUE = 2'd2,
        TS_OWN   = 2'd3
    } tstate_e;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_LOCK   = 2'd1,
        OP_UNLOCK = 2'd2
    } op_e;

    // Request chosen for this cycle.
    typedef struct packed {
        logic valid;
        op_e  op;
        tid_t tid;
    } req_t;

    // Write port into the thread state table.
    typedef struct packed {
        logic    en;
        tid_t    tid;
        tstate_e st;
    } st_wr_t;

    // Response to the served thread.
    typedef struct packed {
        logic complete;
        logic halt;
        logic err;
    } resp_t;

    // Result of the handover search.
    typedef struct packed {
        logic found;
        tid_t tid;
    } pick_t;

    // Outcome of a lock request.
    typedef struct packed {
        tstate_e nxt;
        resp_t   rsp;
        logic    take;
    } lock_out_t;

    function automatic lock_out_t lock_decide(tstate_e cur, logic held);
        lock_out_t o;
        o = '0;
        if (!held) begin
            o.nxt          = TS_OWN;
            o.rsp.complete = 1'b1;
            o.take         = 1'b1;
        end else begin
            case (cur)
                TS_QUEUE: begin
                    o.nxt          = TS_OWN;
                    o.rsp.complete = 1'b1;
                end
                TS_OWN: begin
                    o.nxt          = TS_OWN;
                    o.rsp.complete = 1'b1;
                    o.rsp.halt     = 1'b1;
                    o.rsp.err      = 1'b1;
                end
                default: begin
                    o.nxt      = TS_WAIT;
                    o.rsp.halt = 1'b1;
                end
            endcase
        end
        return o;
    endfunction

    function automatic logic unlock_ok(tstate_e cur, logic held);
        return held && (cur == TS_OWN);
    endfunction

endpackage

// File: rtl/lock_req_select.sv
module lock_req_select
    import lock_arb_pkg::*;
#(
    parameter int N_THREADS = 4
) (
    input  logic [N_THREADS-1:0] lock_req,
    input  logic [N_THREADS-1:0] unlock_req,
    output req_t                 req
);

    // Descending scan: the last hit, and so the lowest index, wins.
    always_comb begin
        req = '0;
        for (int i = N_THREADS - 1; i >= 0; i--) begin
            if (lock_req[i] || unlock_req[i]) begin
                req.valid = 1'b1;
                req.tid   = tid_t'(i);
                req.op    = lock_req[i] ? OP_LOCK : OP_UNLOCK;
            end
        end
    end

endmodule

// File: rtl/lock_rr_pick.sv
module lock_rr_pick
    import lock_arb_pkg::*;
#(
    parameter int N_THREADS = 4
) (
    input  logic [N_THREADS-1:0] wait_v,
    input  tid_t                 start,
    output pick_t                pick
);

    logic found_hi;
    logic found_lo;
    tid_t tid_hi;
    tid_t tid_lo;

    // Two passes: the lowest waiter above the releaser, or else the lowest
    // waiter at or below it (the wrapped part of the circle).
    always_comb begin
        found_hi = 1'b0;
        found_lo = 1'b0;
        tid_hi   = '0;
        tid_lo   = '0;
        for (int i = 0; i < N_THREADS; i++) begin
            if (wait_v[i]) begin
                if (i > int'(start)) begin
                    if (!found_hi) begin
                        found_hi = 1'b1;
                        tid_hi   = tid_t'(i);
                    end
                end else if (!found_lo) begin
                    found_lo = 1'b1;
                    tid_lo   = tid_t'(i);
                end
            end
        end
        pick.found = found_hi || found_lo;
        pick.tid   = found_hi ? tid_hi : tid_lo;
    end

endmodule

// File: rtl/lock_thread_table.sv
module lock_thread_table
    import lock_arb_pkg::*;
#(
    parameter int N_THREADS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  st_wr_t               wr_a,
    input  st_wr_t               wr_b,
    output tstate_e              st_o [N_THREADS],
    output logic [N_THREADS-1:0] wait_v
);

    for (genvar g = 0; g < N_THREADS; g++) begin : g_thr
        tstate_e st_q;

        // Port A serves the requester, port B the handover target; they
        // never address the same thread in one cycle.
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q <= TS_FREE;
            end else if (wr_a.en && (wr_a.tid == tid_t'(g))) begin
                st_q <= wr_a.st;
            end else if (wr_b.en && (wr_b.tid == tid_t'(g))) begin
                st_q <= wr_b.st;
            end
        end

        assign st_o[g]   = st_q;
        assign wait_v[g] = (st_q == TS_WAIT);
    end

endmodule

// File: rtl/lock_arbiter.sv
module lock_arbiter
    import lock_arb_pkg::*;
#(
    parameter int N_THREADS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_THREADS-1:0] lock_req,
    input  logic [N_THREADS-1:0] unlock_req,
    output logic [N_THREADS-1:0] complete,
    output logic [N_THREADS-1:0] halt,
    output logic [N_THREADS-1:0] wake,
    output logic [N_THREADS-1:0] err,
    output logic                 lock_held
);

    localparam int IW = (N_THREADS > 1) ? $clog2(N_THREADS) : 1;

    req_t                 req;
    pick_t                pick;
    st_wr_t               wr_a;
    st_wr_t               wr_b;
    tstate_e              st [N_THREADS];
    logic [N_THREADS-1:0] wait_v;
    tstate_e              cur;
    resp_t                rsp;
    lock_out_t            lk;
    logic                 wake_v;
    logic                 held_q;
    logic                 held_n;

    lock_req_select #(.N_THREADS(N_THREADS)) u_sel (
        .lock_req   (lock_req),
        .unlock_req (unlock_req),
        .req        (req)
    );

    lock_thread_table #(.N_THREADS(N_THREADS)) u_tbl (
        .clk    (clk),
        .rst    (rst),
        .wr_a   (wr_a),
        .wr_b   (wr_b),
        .st_o   (st),
        .wait_v (wait_v)
    );

    lock_rr_pick #(.N_THREADS(N_THREADS)) u_pick (
        .wait_v (wait_v),
        .start  (req.tid),
        .pick   (pick)
    );

    assign cur = st[req.tid[IW-1:0]];

    always_comb begin
        wr_a   = '0;
        wr_b   = '0;
        rsp    = '0;
        wake_v = 1'b0;
        held_n = held_q;
        lk     = lock_decide(cur, held_q);
        if (req.valid && (req.op == OP_LOCK)) begin
            wr_a = '{en: 1'b1, tid: req.tid, st: lk.nxt};
            rsp  = lk.rsp;
            if (lk.take) begin
                held_n = 1'b1;
            end
        end else if (req.valid && (req.op == OP_UNLOCK)) begin
            if (unlock_ok(cur, held_q)) begin
                wr_a         = '{en: 1'b1, tid: req.tid, st: TS_FREE};
                rsp.complete = 1'b1;
                if (pick.found) begin
                    wr_b   = '{en: 1'b1, tid: pick.tid, st: TS_QUEUE};
                    wake_v = 1'b1;
                end else begin
                    held_n = 1'b0;
                end
            end else begin
                rsp.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q   <= 1'b0;
            complete <= '0;
            halt     <= '0;
            wake     <= '0;
            err      <= '0;
        end else begin
            held_q <= held_n;
            for (int i = 0; i < N_THREADS; i++) begin
                complete[i] <= rsp.complete && (req.tid == tid_t'(i));
                halt[i]     <= rsp.halt     && (req.tid == tid_t'(i));
                err[i]      <= rsp.err      && (req.tid == tid_t'(i));
                wake[i]     <= wake_v       && (pick.tid == tid_t'(i));
            end
        end
    end

    assign lock_held = held_q;

endmodule

// File: rtl/lock_arbiter_chk.sv
module lock_arbiter_chk #(
    parameter int N_THREADS = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic [N_THREADS-1:0] complete,
    input logic [N_THREADS-1:0] halt,
    input logic [N_THREADS-1:0] wake,
    input logic [N_THREADS-1:0] err,
    input logic                 lock_held
);

    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R1
    always @(posedge clk) begin
        if ((rst_d === 1'b1) && !rst) begin
            reset_clear_chk: assert (!lock_held && complete == '0 && halt == '0
                                     && wake == '0 && err == '0);
        end
    end

    // R11
    one_cmp_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(complete));

    // R11
    one_halt_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(halt));

    // R11
    one_err_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(err));

    // R11
    one_wake_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wake));

    // R2
    take_cmp_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(lock_held) && !$past(rst)) |-> (complete != '0));

    // R4
    dbl_lock_chk: assert property (@(posedge clk) disable iff (rst)
        ((halt & complete) != '0) |-> (err == (halt & complete)));

    // R5
    bad_unlock_chk: assert property (@(posedge clk) disable iff (rst)
        ((err & ~halt) != '0) |-> ($stable(lock_held) && complete == '0));

    // R6
    drop_cmp_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(lock_held) && !$past(rst)) |-> (complete != '0 && wake == '0));

    // R7
    wake_hand_chk: assert property (@(posedge clk) disable iff (rst)
        (wake != '0) |-> (lock_held && complete != '0 && (wake & complete) == '0));

endmodule

bind lock_arbiter lock_arbiter_chk #(.N_THREADS(N_THREADS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .complete  (complete),
    .halt      (halt),
    .wake      (wake),
    .err       (err),
    .lock_held (lock_held)
);

// File: tb/sim_lock_arbiter.sv
`timescale 1ns/1ps
module sim_lock_arbiter;

    localparam int N  = 4;
    localparam int NV = 22;

    // {req tag, lock_req, unlock_req, complete, halt, wake, err, lock_held}
    localparam logic [28:0] VEC [NV] = '{
        {4'd2,  4'b0001, 4'b0000, 4'b0001, 4'b0000, 4'b0000, 4'b0000, 1'b1}, // R2 T0 takes free lock
        {4'd3,  4'b0100, 4'b0000, 4'b0000, 4'b0100, 4'b0000, 4'b0000, 1'b1}, // R3 T2 waits
        {4'd3,  4'b1000, 4'b0000, 4'b0000, 4'b1000, 4'b0000, 4'b0000, 1'b1}, // R3 T3 waits
        {4'd3,  4'b0010, 4'b0000, 4'b0000, 4'b0010, 4'b0000, 4'b0000, 1'b1}, // R3 T1 waits
        {4'd7,  4'b0000, 4'b0001, 4'b0001, 4'b0000, 4'b0010, 4'b0000, 1'b1}, // R7 T0 -> T1
        {4'd3,  4'b1000, 4'b0000, 4'b0000, 4'b1000, 4'b0000, 4'b0000, 1'b1}, // R3 waiter retries
        {4'd5,  4'b0000, 4'b0010, 4'b0000, 4'b0000, 4'b0000, 4'b0010, 1'b1}, // R5 queued unlock
        {4'd8,  4'b0010, 4'b0000, 4'b0010, 4'b0000, 4'b0000, 4'b0000, 1'b1}, // R8 T1 owns
        {4'd4,  4'b0010, 4'b0000, 4'b0010, 4'b0010, 4'b0000, 4'b0010, 1'b1}, // R4 double lock
        {4'd7,  4'b0000, 4'b0010, 4'b0010, 4'b0000, 4'b0100, 4'b0000, 1'b1}, // R7 T1 -> T2
        {4'd9,  4'b0101, 4'b0000, 4'b0000, 4'b0001, 4'b0000, 4'b0000, 1'b1}, // R9 T0 wins tie
        {4'd8,  4'b0100, 4'b0000, 4'b0100, 4'b0000, 4'b0000, 4'b0000, 1'b1}, // R8 T2 owns
        {4'd7,  4'b0000, 4'b0100, 4'b0100, 4'b0000, 4'b1000, 4'b0000, 1'b1}, // R7 T2 -> T3
        {4'd8,  4'b1000, 4'b0000, 4'b1000, 4'b0000, 4'b0000, 4'b0000, 1'b1}, // R8 T3 owns
        {4'd7,  4'b0000, 4'b1000, 4'b1000, 4'b0000, 4'b0001, 4'b0000, 1'b1}, // R7 wrap T3 -> T0
        {4'd8,  4'b0001, 4'b0000, 4'b0001, 4'b0000, 4'b0000, 4'b0000, 1'b1}, // R8 T0 owns
        {4'd6,  4'b0000, 4'b0001, 4'b0001, 4'b0000, 4'b0000, 4'b0000, 1'b0}, // R6 release, none wait
        {4'd5,  4'b0000, 4'b0100, 4'b0000, 4'b0000, 4'b0000, 4'b0100, 1'b0}, // R5 unlock when clear
        {4'd10, 4'b0010, 4'b0010, 4'b0010, 4'b0000, 4'b0000, 4'b0000, 1'b1}, // R10 lock wins
        {4'd9,  4'b0000, 4'b0011, 4'b0000, 4'b0000, 4'b0000, 4'b0001, 1'b1}, // R9 T0 served, T1 dropped
        {4'd6,  4'b0000, 4'b0010, 4'b0010, 4'b0000, 4'b0000, 4'b0000, 1'b0}, // R6 T1 still owned
        {4'd11, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0}  // R11 pulses ended
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] lock_req = '0;
    logic [N-1:0] unlock_req = '0;
    logic [N-1:0] complete, halt, wake, err;
    logic         lock_held;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    lock_arbiter #(.N_THREADS(N)) u0 (
        .clk        (clk),
        .rst        (rst),
        .lock_req   (lock_req),
        .unlock_req (unlock_req),
        .complete   (complete),
        .halt       (halt),
        .wake       (wake),
        .err        (err),
        .lock_held  (lock_held)
    );

    function automatic logic [16:0] outs();
        return {complete, halt, wake, err, lock_held};
    endfunction

    task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %05h expected %05h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [N-1:0] lk, input logic [N-1:0] ul);
        lock_req   = lk;
        unlock_req = ul;
        @(negedge clk);
        lock_req   = '0;
        unlock_req = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset state", outs(), 17'h0);

        for (int k = 0; k < NV; k++) begin
            drive(VEC[k][24:21], VEC[k][20:17]);
            check($sformatf("R%0d vector %0d", VEC[k][28:25], k), outs(), VEC[k][16:0]);
        end

        // R1: reset mid-run drops an owner
        drive(4'b0100, 4'b0000);
        check("R2 owner before reset", outs(), {4'b0100, 4'b0, 4'b0, 4'b0, 1'b1});
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset clears held", outs(), 17'h0);
        drive(4'b0010, 4'b0000);
        check("R1 lock free after reset", outs(), {4'b0010, 4'b0, 4'b0, 4'b0, 1'b1});
        drive(4'b0000, 4'b0100);
        check("R5 old owner unlock after reset", outs(), {4'b0, 4'b0, 4'b0, 4'b0100, 1'b1});
        drive(4'b0000, 4'b0010);
        check("R6 release after reset", outs(), {4'b0010, 4'b0, 4'b0, 4'b0, 1'b0});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule